// File: doc/BRIEF.md
# Limited-Pointer Sharer Entry with Overflow Handling

This block holds the sharer record for one memory line in a distributed directory. Sharers are kept as a small set of node-number pointers, each `$clog2(NODES)` bits wide (a 1024-node system needs 10-bit pointers). There is also an overflow flag. When a new sharer arrives and every slot already holds a different node, the block handles it under one of three selectable policies. Under broadcast, it gives up exact tracking and later invalidates the whole machine. Under no-broadcast, it evicts one recorded sharer and invalidates that node. Under coarse vector, it reuses the pointer bits as a bit map in which each bit stands for a group of nodes.

The surrounding protocol engine issues one command at a time: add a sharer, clear the entry, or write by a given node. A write, or an eviction under no-broadcast, makes the block list its invalidation targets. It sends one node number per cycle, in ascending order, and then gives a one-cycle done pulse. While a list is being sent the block refuses new commands.

Top module: `lptr_dir_entry`

## Requirements
- R1: After reset the entry is empty, `cmd_ready` is 1 and neither `inv_valid` nor `inv_done` is asserted; a write to an empty entry yields no target.
- R2: Commands are accepted when `cmd_valid` and `cmd_ready` are both 1. `cmd_op` encodes 0 = add sharer, 1 = clear, 2 = write; 3 is ignored. Up to PTRS distinct added nodes are recorded exactly, and a later write invalidates exactly those nodes.
- R3: Adding a node that is already recorded changes nothing: no slot is used, no overflow happens, and no target is produced.
- R4: `policy` 0 (and 3) selects broadcast. Adding a new node to a full entry sets overflow, and the next write invalidates every node 0..NODES-1 except the writer.
- R5: `policy` 1 selects no-broadcast. Adding a new node to a full entry replaces the slot named by a round-robin index that starts at slot 0 and advances by one per eviction. The displaced node is sent as a single target the cycle after the add, followed by a done pulse.
- R6: `policy` 2 selects coarse vector, with group size G = ceil(NODES / (PTRS·ID_W)) and node n belonging to bit n / G. On overflow the groups of all recorded nodes and of the new node are marked. Later adds mark their group. A write invalidates every node of every marked group except the writer.
- R7: The writing node is never among its own write's targets; if it is the only sharer, the done pulse comes with no target.
- R8: Targets appear one per cycle without gaps and in ascending order, starting the cycle after the command. `inv_done` pulses in the cycle after the last target (or the cycle after the command if there is none). `cmd_ready` is 0 from the cycle after the command through the done cycle.
- R9: A clear empties the entry and drops overflow; a later write yields no target.
- R10: After a write, the entry holds only the writer, with overflow cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Overflow policy: 0 broadcast, 1 no-broadcast, 2 coarse vector; change only while empty |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 add, 1 clear, 2 write |
| cmd_node | input | $clog2(NODES) | Node number of the sharer or writer |
| cmd_ready | output | 1 | Block can accept a command |
| inv_valid | output | 1 | A target node number is on `inv_node` |
| inv_node | output | $clog2(NODES) | Node to invalidate |
| inv_done | output | 1 | One-cycle pulse ending a target list |

## Verification
The bench builds the block with NODES = 16 and PTRS = 2, which gives 4-bit pointers and an 8-bit coarse map with two nodes per group. At that size overflow needs only a third distinct sharer. A broadcast write produces fifteen targets, so the gap-free, ascending listing is tested over a long run. The round-robin eviction wraps after two evictions, and a coarse write shows a writer excluded from inside its own marked group.

// File: rtl/lpd_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the limited-pointer sharer entry.
// Assumes: commands and policies are two-bit codes driven by the protocol engine.
package lpd_pkg;
    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_CLEAR = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } lpd_op_e;

    typedef enum logic [1:0] {
        POL_BCAST  = 2'd0,
        POL_NOBC   = 2'd1,
        POL_COARSE = 2'd2,
        POL_RSVD   = 2'd3
    } lpd_pol_e;
endpackage

// File: rtl/lpd_dup_match.sv
`timescale 1ns/1ps
// Compares a node number against every occupied pointer slot.
// Assumes: slots 0..count-1 are occupied; only meaningful while not overflowed.
module lpd_dup_match #(
    parameter int NODES = 16,
    parameter int PTRS  = 2,
    localparam int ID_W  = $clog2(NODES),
    localparam int SW    = PTRS * ID_W,
    localparam int CNT_W = $clog2(PTRS + 1)
) (
    input  logic [SW-1:0]    store,
    input  logic [CNT_W-1:0] count,
    input  logic [ID_W-1:0]  node,
    output logic             hit
);
    logic [PTRS-1:0] slot_hit;

    for (genvar s = 0; s < PTRS; s++) begin : g_slot
        // One comparator per slot, qualified by occupancy.
        assign slot_hit[s] = (int'(count) > s) && (store[s*ID_W +: ID_W] == node);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/lpd_target_mask.sv
`timescale 1ns/1ps
// Expands the stored sharer record into a per-node membership mask for a write.
// Assumes: in coarse overflow the storage word is a group bit map; the
// excluded node (the writer) is removed from the result.
module lpd_target_mask #(
    parameter int NODES = 16,
    parameter int PTRS  = 2,
    localparam int ID_W  = $clog2(NODES),
    localparam int SW    = PTRS * ID_W,
    localparam int CNT_W = $clog2(PTRS + 1),
    localparam int GRP   = (NODES + SW - 1) / SW
) (
    input  logic [SW-1:0]    store,
    input  logic [CNT_W-1:0] count,
    input  logic             ovf,
    input  logic [1:0]       policy,
    input  logic [ID_W-1:0]  excl_node,
    output logic [NODES-1:0] mask
);
    import lpd_pkg::*;

    logic [NODES-1:0] coarse_mask;
    logic [NODES-1:0] exact_mask;

    for (genvar n = 0; n < NODES; n++) begin : g_node
        // Each node inherits the bit of the group it belongs to.
        assign coarse_mask[n] = store[n / GRP];
    end

    // Exact membership from the occupied pointer slots.
    always_comb begin
        exact_mask = '0;
        for (int s = 0; s < PTRS; s++) begin
            if (int'(count) > s) exact_mask[store[s*ID_W +: ID_W]] = 1'b1;
        end
    end

    // Select the representation, then drop the excluded node.
    always_comb begin
        if (!ovf)                              mask = exact_mask;
        else if (policy == 2'(POL_COARSE))     mask = coarse_mask;
        else                                   mask = '1;
        mask[excl_node] = 1'b0;
    end
endmodule

// File: rtl/lpd_inv_walker.sv
`timescale 1ns/1ps
// Emits the set bits of a loaded mask as node numbers, lowest first, one per
// cycle, then a one-cycle done pulse. Busy from the cycle after load to done.
// Assumes: load is only asserted while not busy.
module lpd_inv_walker #(
    parameter int NODES = 16,
    localparam int ID_W = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NODES-1:0] load_mask,
    output logic             busy,
    output logic             inv_valid,
    output logic [ID_W-1:0]  inv_node,
    output logic             inv_done
);
    logic [NODES-1:0] pend_q;
    logic             busy_q;

    // Pending-target register and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            pend_q <= load_mask;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            pend_q <= pend_q & (pend_q - 1'b1);
            if (pend_q == '0) busy_q <= 1'b0;
        end
    end

    // Lowest pending node number.
    always_comb begin
        inv_node = '0;
        for (int n = NODES - 1; n >= 0; n--) begin
            if (pend_q[n]) inv_node = ID_W'(n);
        end
    end

    assign busy      = busy_q;
    assign inv_valid = busy_q && (pend_q != '0);
    assign inv_done  = busy_q && (pend_q == '0);

    // R8: consecutive targets strictly ascend.
    assert_targets_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && $past(inv_valid) |-> inv_node > $past(inv_node));
    // R8: after a done pulse the walker is idle again.
    assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !busy);
endmodule

// File: rtl/lptr_dir_entry.sv
`timescale 1ns/1ps
// One limited-pointer directory entry with selectable overflow policy.
// Holds PTRS node pointers plus an overflow flag; on coarse overflow the
// pointer bits become a group bit map. Writes and no-broadcast evictions
// produce a target list through the walker.
// Assumes: policy changes only while the entry is empty; one command per
// accepted handshake; the storage array around it is out of scope.
module lptr_dir_entry #(
    parameter int NODES = 16,
    parameter int PTRS  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               policy,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [$clog2(NODES)-1:0] cmd_node,
    output logic                     cmd_ready,
    output logic                     inv_valid,
    output logic [$clog2(NODES)-1:0] inv_node,
    output logic                     inv_done
);
    import lpd_pkg::*;

    localparam int ID_W   = $clog2(NODES);
    localparam int SW     = PTRS * ID_W;
    localparam int CNT_W  = $clog2(PTRS + 1);
    localparam int SLOT_W = (PTRS > 1) ? $clog2(PTRS) : 1;
    localparam int GRP    = (NODES + SW - 1) / SW;

    logic [SW-1:0]     store_q, store_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ovf_q, ovf_d;
    logic [SLOT_W-1:0] rr_q, rr_d;
    logic              wr_walk_q, wr_walk_d;

    logic             accept, hit, full, busy, load;
    logic [NODES-1:0] share_mask, load_mask;
    logic [ID_W-1:0]  victim;

    function automatic int grp_of(input logic [ID_W-1:0] n);
        return int'(n) / GRP;
    endfunction

    lpd_dup_match #(.NODES(NODES), .PTRS(PTRS)) u_dup (
        .store(store_q), .count(cnt_q), .node(cmd_node), .hit(hit)
    );

    lpd_target_mask #(.NODES(NODES), .PTRS(PTRS)) u_mask (
        .store(store_q), .count(cnt_q), .ovf(ovf_q), .policy(policy),
        .excl_node(cmd_node), .mask(share_mask)
    );

    lpd_inv_walker #(.NODES(NODES)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .load_mask(load_mask),
        .busy(busy), .inv_valid(inv_valid), .inv_node(inv_node), .inv_done(inv_done)
    );

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign full      = (int'(cnt_q) == PTRS);

    // Pointer currently named by the round-robin index.
    always_comb begin
        victim = '0;
        for (int s = 0; s < PTRS; s++) begin
            if (int'(rr_q) == s) victim = store_q[s*ID_W +: ID_W];
        end
    end

    // Next-state of the entry and the walker load request.
    always_comb begin
        store_d   = store_q;
        cnt_d     = cnt_q;
        ovf_d     = ovf_q;
        rr_d      = rr_q;
        wr_walk_d = wr_walk_q;
        load      = 1'b0;
        load_mask = '0;
        if (accept) begin
            case (cmd_op)
                2'(OP_ADD): begin
                    if (!ovf_q) begin
                        if (hit) begin
                            // already recorded: nothing changes
                        end else if (!full) begin
                            for (int s = 0; s < PTRS; s++) begin
                                if (int'(cnt_q) == s) store_d[s*ID_W +: ID_W] = cmd_node;
                            end
                            cnt_d = cnt_q + 1'b1;
                        end else if (policy == 2'(POL_NOBC)) begin
                            for (int s = 0; s < PTRS; s++) begin
                                if (int'(rr_q) == s) store_d[s*ID_W +: ID_W] = cmd_node;
                            end
                            rr_d = (int'(rr_q) == PTRS - 1) ? '0 : rr_q + 1'b1;
                            load = 1'b1;
                            load_mask[victim] = 1'b1;
                            wr_walk_d = 1'b0;
                        end else if (policy == 2'(POL_COARSE)) begin
                            store_d = '0;
                            for (int s = 0; s < PTRS; s++) begin
                                store_d[grp_of(store_q[s*ID_W +: ID_W])] = 1'b1;
                            end
                            store_d[grp_of(cmd_node)] = 1'b1;
                            ovf_d = 1'b1;
                        end else begin
                            ovf_d = 1'b1;
                        end
                    end else if (policy == 2'(POL_COARSE)) begin
                        store_d[grp_of(cmd_node)] = 1'b1;
                    end
                end
                2'(OP_CLEAR): begin
                    store_d = '0;
                    cnt_d   = '0;
                    ovf_d   = 1'b0;
                    rr_d    = '0;
                end
                2'(OP_WRITE): begin
                    load      = 1'b1;
                    load_mask = share_mask;
                    store_d   = '0;
                    store_d[ID_W-1:0] = cmd_node;
                    cnt_d     = CNT_W'(1);
                    ovf_d     = 1'b0;
                    rr_d      = '0;
                    wr_walk_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Entry state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q   <= '0;
            cnt_q     <= '0;
            ovf_q     <= 1'b0;
            rr_q      <= '0;
            wr_walk_q <= 1'b0;
        end else begin
            store_q   <= store_d;
            cnt_q     <= cnt_d;
            ovf_q     <= ovf_d;
            rr_q      <= rr_d;
            wr_walk_q <= wr_walk_d;
        end
    end

    // R2: the occupancy never exceeds the slot count.
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= PTRS);
    // R3: a duplicate add leaves the record untouched.
    assert_dup_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_op == 2'(OP_ADD) && !ovf_q && hit |=> $stable(store_q) && $stable(cnt_q));
    // R5: an eviction puts the displaced node out in the next cycle.
    assert_evict_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_op == 2'(OP_ADD) && !ovf_q && !hit && full && policy == 2'(POL_NOBC)
        |=> inv_valid);
    // R7: a write never targets the writer (held in slot 0 during the walk).
    assert_writer_excluded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && wr_walk_q |-> inv_node != store_q[ID_W-1:0]);
endmodule

// File: tb/tb_lptr_dir_entry.sv
`timescale 1ns/1ps
module tb_lptr_dir_entry;
    localparam int NODES = 16;
    localparam int PTRS  = 2;
    localparam int ID_W  = $clog2(NODES);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      policy = 2'd0;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = 2'd0;
    logic [ID_W-1:0] cmd_node = '0;
    logic            cmd_ready, inv_valid, inv_done;
    logic [ID_W-1:0] inv_node;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lptr_dir_entry #(.NODES(NODES), .PTRS(PTRS)) dut (
        .clk(clk), .rst_n(rst_n), .policy(policy), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_node(cmd_node), .cmd_ready(cmd_ready),
        .inv_valid(inv_valid), .inv_node(inv_node), .inv_done(inv_done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one command; returns at the falling edge after acceptance.
    task automatic cmd(input logic [1:0] op, input int node);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_node = ID_W'(node);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Collect a target list starting in the current cycle and compare.
    task automatic walk(input logic [NODES-1:0] exp, input string tag);
        logic [NODES-1:0] got = '0;
        int  n = 0, prev = -1;
        bit  order_ok = 1'b1;
        while (!inv_done && n < 64) begin
            if (inv_valid) begin
                got[inv_node] = 1'b1;
                if (int'(inv_node) <= prev) order_ok = 1'b0;
                prev = int'(inv_node);
            end
            chk(!cmd_ready, {tag, " R8 ready low"}, cmd_ready, 0);
            n++;
            @(negedge clk);
        end
        chk(inv_done && !inv_valid, {tag, " R8 done pulse"}, inv_done, 1);
        chk(got == exp, {tag, " target set"}, got, exp);
        chk(n == $countones(exp), {tag, " R8 one per cycle"}, n, $countones(exp));
        chk(order_ok, {tag, " R8 ascending"}, order_ok, 1);
        @(negedge clk);
        chk(!inv_done && cmd_ready, {tag, " R8 done single"}, inv_done, 0);
    endtask

    task automatic write_walk(input int writer, input logic [NODES-1:0] exp, input string tag);
        cmd(2'd2, writer);
        walk(exp, tag);
    endtask

    task automatic t_reset();
        chk(cmd_ready && !inv_valid && !inv_done, "R1 reset outputs",
            {cmd_ready, inv_valid, inv_done}, 3'b100);
        write_walk(0, 16'h0000, "R1 empty write");
    endtask

    task automatic t_exact();
        policy = 2'd0;
        cmd(2'd1, 0);
        cmd(2'd0, 3); cmd(2'd0, 9);
        write_walk(5, 16'h0208, "R2 exact sharers");
    endtask

    task automatic t_dup();
        policy = 2'd0;
        cmd(2'd1, 0);
        cmd(2'd0, 4); cmd(2'd0, 4); cmd(2'd0, 11);
        write_walk(0, 16'h0810, "R3 duplicate add");
    endtask

    task automatic t_bcast();
        policy = 2'd0;
        cmd(2'd1, 0);
        cmd(2'd0, 1); cmd(2'd0, 2); cmd(2'd0, 3);
        write_walk(7, 16'hFF7F, "R4 broadcast");
        write_walk(12, 16'h0080, "R10 writer kept");
    endtask

    task automatic t_nobc();
        policy = 2'd1;
        cmd(2'd1, 0);
        cmd(2'd0, 1); cmd(2'd0, 2);
        cmd(2'd0, 3);
        walk(16'h0002, "R5 first victim");
        cmd(2'd0, 4);
        walk(16'h0004, "R5 round robin victim");
        cmd(2'd0, 3);
        chk(!inv_valid && !inv_done, "R3 dup on full no victim", inv_valid, 0);
        write_walk(0, 16'h0018, "R5 surviving sharers");
    endtask

    task automatic t_coarse();
        policy = 2'd2;
        cmd(2'd1, 0);
        cmd(2'd0, 2); cmd(2'd0, 9); cmd(2'd0, 12);
        cmd(2'd0, 15);
        write_walk(3, 16'hF304, "R6 coarse groups");
        policy = 2'd0;
    endtask

    task automatic t_self();
        cmd(2'd1, 0);
        cmd(2'd0, 6);
        write_walk(6, 16'h0000, "R7 writer only");
    endtask

    task automatic t_clear();
        cmd(2'd1, 0);
        cmd(2'd0, 5); cmd(2'd0, 6);
        cmd(2'd1, 0);
        write_walk(0, 16'h0000, "R9 clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_dup();
        t_bcast();
        t_nobc();
        t_coarse();
        t_self();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule